// File: doc/BRIEF.md
# Token-Ring Polled Status Bus Driver

Each queue device in a daisy chain owns a slice of a shared status bus only while it holds a one-cycle token. The token enters on `tok_in` and is captured at a write-clock rising edge. For the following cycle the device does three things: it drives the almost-full bits of all of its queues onto the bus, raises its bus-drive enable and raises its frame-sync output. In that same cycle it presents the token on `tok_out`, so the next device in the ring captures it at the next edge. The last device's `tok_out` feeds the first device's `tok_in`, which closes the ring. A lone device in polled mode wires its own `tok_out` to its own `tok_in` and so owns the bus on every cycle.

After reset no token exists yet. The device strapped as master creates the first one at the first rising edge after reset is released. Slaves stay silent until a token reaches them. In direct mode the token logic is bypassed: the bus continuously shows this device's own almost-full bits and the chain outputs stay low. All logic is synchronous to the write clock.

Top module: `polled_status_bus`

## Requirements
- R1: In polled mode, if `tok_in` is 1 at a rising edge, then for the next clock cycle `bus_oe`=1 and `stat_bus` equals the value `af_vec` had at that edge. `stat_bus` stays at that value even if `af_vec` changes during the cycle.
- R2: In polled mode, `tok_out` is 1 in exactly the cycles in which the device owns the bus. A single-cycle pulse on `tok_in` yields a single-cycle pulse on `tok_out`.
- R3: In polled mode, `fsync` is 1 in exactly the cycles in which the device's status is on the bus.
- R4: In polled mode, a device that does not hold the token drives `bus_oe`=0, `stat_bus`=0, `tok_out`=0 and `fsync`=0.
- R5: A device with `is_master`=1 in polled mode owns the bus for one cycle starting at the first rising edge after `rst_n` rises, with no `tok_in`. It injects a token only once per reset.
- R6: A device with `is_master`=0 never owns the bus after reset until `tok_in` is seen high at an edge.
- R7: With `tok_out` looped back to `tok_in`, a master device owns the bus on every cycle after injection. Each cycle `stat_bus` shows `af_vec` as sampled at the preceding edge.
- R8: In direct mode (`mode_polled`=0), `tok_in` is ignored. `bus_oe`=1, `stat_bus` follows `af_vec` within the same cycle, and `tok_out`=0 and `fsync`=0.
- R9: While `rst_n`=0 in polled mode, `bus_oe`, `stat_bus`, `tok_out` and `fsync` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| mode_polled | input | 1 | 1 = token-polled bus, 0 = direct pass-through |
| is_master | input | 1 | 1 = this device injects the first token after reset |
| tok_in | input | 1 | Token from the previous device in the ring |
| af_vec | input | NQ | Almost-full flags of this device's queues |
| stat_bus | output | NQ | Status bus lines (driven value) |
| bus_oe | output | 1 | Bus-drive enable for this device |
| tok_out | output | 1 | Token to the next device in the ring |
| fsync | output | 1 | High while this device's status occupies the bus |

## Verification
The bench checks that captured status is taken at the token edge and held. A design that passes `af_vec` straight through during ownership would show a mid-cycle change on the bus. It checks that a one-cycle token gives exactly one cycle of ownership, since a sticky ownership flag would collide with the next device. Master injection is probed both for its timing and for happening only once, so a design that re-injects would put two tokens into the ring. The self-loop case and direct mode with a toggling `tok_in` expose designs that drop the loopback token or still react to the chain input.

// File: rtl/polled_status_bus.sv
module polled_status_bus #(
  parameter int NQ = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_polled,
  input  logic          is_master,
  input  logic          tok_in,
  input  logic [NQ-1:0] af_vec,
  output logic [NQ-1:0] stat_bus,
  output logic          bus_oe,
  output logic          tok_out,
  output logic          fsync
);

  logic          own_q;
  logic          started_q;
  logic [NQ-1:0] grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q     <= 1'b0;
      started_q <= 1'b0;
      grp_q     <= '0;
    end else begin
      started_q <= 1'b1;
      own_q     <= mode_polled & (tok_in | (is_master & ~started_q));
      grp_q     <= af_vec;
    end
  end

  assign bus_oe   = mode_polled ? own_q : 1'b1;
  assign stat_bus = mode_polled ? (own_q ? grp_q : '0) : af_vec;
  assign tok_out  = mode_polled & own_q;
  assign fsync    = mode_polled & own_q;

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_polled && tok_in) |=> (!mode_polled || (bus_oe && stat_bus == $past(af_vec))));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !tok_in) |=> !tok_out);

  assert_sync_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_polled && tok_in) |=> (!mode_polled || fsync));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_polled && !bus_oe) |-> (stat_bus == '0 && !tok_out && !fsync));

  assert_direct_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_polled |-> (bus_oe && stat_bus == af_vec && !tok_out && !fsync));

endmodule

// File: tb/polled_status_bus_tb.sv
module polled_status_bus_tb_top;
  localparam int NQ = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_polled;
  logic          is_master;
  logic          tok_drv;
  logic          loop_en;
  logic          tok_in;
  logic [NQ-1:0] af_vec;
  logic [NQ-1:0] stat_bus;
  logic          bus_oe, tok_out, fsync;
  int            checks = 0;
  int            failures = 0;

  always #10 clk = ~clk;

  assign tok_in = loop_en ? tok_out : tok_drv;

  polled_status_bus #(.NQ(NQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_polled(mode_polled), .is_master(is_master),
    .tok_in(tok_in), .af_vec(af_vec), .stat_bus(stat_bus), .bus_oe(bus_oe),
    .tok_out(tok_out), .fsync(fsync)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pack();
    return {1'b0, bus_oe, tok_out, fsync, stat_bus};
  endfunction

  task automatic do_reset(input logic polled, input logic master);
    @(negedge clk);
    rst_n = 1'b0; mode_polled = polled; is_master = master;
    tok_drv = 1'b0; loop_en = 1'b0; af_vec = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_and_slave();
    do_reset(1'b1, 1'b0);
    af_vec = 8'hFF;
    #1 chk("R9 reset outputs", pack(), 12'h000);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 chk("R6 slave idle", pack(), 12'h000);
    end
  endtask

  task automatic t_token_pass();
    do_reset(1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); tok_drv = 1'b1; af_vec = 8'hA5;
    @(posedge clk); #1 chk("R1 R2 R3 owned cycle", pack(), {4'b0111, 8'hA5});
    @(negedge clk); tok_drv = 1'b0; af_vec = 8'h3C;
    #1 chk("R1 captured value held", {4'b0, stat_bus}, {4'b0, 8'hA5});
    @(posedge clk); #1 chk("R2 R4 released after one cycle", pack(), 12'h000);
    @(negedge clk); af_vec = 8'h81; tok_drv = 1'b1;
    @(posedge clk); #1 chk("R1 second token", pack(), {4'b0111, 8'h81});
    @(negedge clk); tok_drv = 1'b0;
    @(posedge clk); #1 chk("R3 fsync low when idle", {11'b0, fsync}, 12'h000);
  endtask

  task automatic t_master_inject();
    do_reset(1'b1, 1'b1);
    af_vec = 8'h42;
    #1 chk("R9 master in reset", pack(), 12'h000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R5 master injects", pack(), {4'b0111, 8'h42});
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1 chk("R5 single injection", pack(), 12'h000);
    end
  endtask

  task automatic t_loopback();
    do_reset(1'b1, 1'b1);
    loop_en = 1'b1;
    @(negedge clk); rst_n = 1'b1; af_vec = 8'h10;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = af_vec;
      @(posedge clk); #1 chk("R7 loopback ownership", pack(), {4'b0111, v});
      @(negedge clk); af_vec = v + 8'h11;
    end
  endtask

  task automatic t_direct();
    do_reset(1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1; af_vec = 8'h5A; tok_drv = 1'b1;
    @(posedge clk); #1 chk("R8 direct passthrough", pack(), {4'b0100, 8'h5A});
    @(negedge clk); af_vec = 8'hC3; tok_drv = 1'b0;
    #1 chk("R8 direct same cycle", pack(), {4'b0100, 8'hC3});
    @(posedge clk); #1 chk("R8 token ignored", pack(), {4'b0100, 8'hC3});
  endtask

  initial begin
    rst_n = 1'b0; mode_polled = 1'b1; is_master = 1'b0;
    tok_drv = 1'b0; loop_en = 1'b0; af_vec = '0;
    t_reset_and_slave();
    t_token_pass();
    t_master_inject();
    t_loopback();
    t_direct();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule